// File: doc/BRIEF.md
# Dual-Polynomial Side-Stream Scrambler

This block produces the pseudo-random side stream that a gigabit copper transmitter uses to whiten its line symbols. A 33-bit shift register with a single XOR feedback advances once per symbol clock, which is one transmit byte per cycle at 125 MHz. A run-time select picks one of two feedback polynomials, so the two ends of a link can run sequences that are not correlated with each other. From the register contents the block derives, every cycle and without extra latency, three groups of auxiliary bits that later encoding and mapping stages consume alongside the raw sequence bit.

A load strobe writes a 33-bit seed. An all-zero seed is replaced by the value 1, so the register can never sit in the all-zero state, where it would stop producing a sequence. While the advance enable is low, the register and every derived output keep their values.

Top module: `side_stream_scrambler`

## Requirements
- R1: A synchronous active-high reset sets the register to 33'h1_2345_6789, and all outputs reflect that state from the first cycle after reset.
- R2: With the role select high, each advance shifts the register up by one (bit k+1 takes bit k) and writes bit 32 XOR bit 12 into bit 0 (polynomial 1 + x^13 + x^33).
- R3: With the role select low, each advance writes bit 32 XOR bit 19 into bit 0 (polynomial 1 + x^20 + x^33), with the same shift.
- R4: A load with a nonzero seed sets the register to that seed on the next clock edge, whether the enable is high or low.
- R5: A load with an all-zero seed sets the register to 33'h1 instead.
- R6: When load and enable are both high in the same cycle, the load wins and no advance takes place.
- R7: With load and enable both low, the register and all outputs hold, and the seed input has no effect.
- R8: Outputs are combinational functions of the register state s. With sx = s[4]^s[6] and sy = s[1]^s[5]: seq_bit = s[0]; sc_bits[i] = s[16+i] ^ (sx for even i, sy for odd i), for i = 0..7; sy_bits[i] = s[8+i]^sy, for i = 0..3; sg_bits[i] = s[24+i]^sx, for i = 0..3.
- R9: The role select may change between any two cycles, and each advance uses the polynomial selected in its own cycle.
- R10: The register is never all zero after reset, so no run of zeros on seq_bit over consecutive advances reaches 33.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Seed load strobe, takes priority over advance |
| seed_i | input | 33 | Seed value written on load |
| role_master_i | input | 1 | 1 selects 1 + x^13 + x^33, 0 selects 1 + x^20 + x^33 |
| adv_en_i | input | 1 | Advance enable |
| seq_bit_o | output | 1 | Raw sequence bit, register bit 0 |
| sc_bits_o | output | 8 | Derived group from bits 16..23 mixed with sx/sy |
| sy_bits_o | output | 4 | Derived group from bits 8..11 mixed with sy |
| sg_bits_o | output | 4 | Derived group from bits 24..27 mixed with sx |

## Verification
The bench runs long stretches in each role against its own shift model. A tap off by one stage, or polynomials swapped between roles, makes seq_bit and the derived groups drift apart from the model within a few dozen cycles. Zero-seed loads, loads with the enable low and loads with the enable high are each placed between runs of advances: a design that skips the substitution hangs at all zeros, and one that lets the enable win advances one step too far. Hold periods with a changing seed input catch a register that leaks the seed or steps without an enable. Toggling the role every cycle catches a select that is registered one cycle late.

// File: rtl/ssscr_pkg.sv
package ssscr_pkg;

    localparam int unsigned SCR_W      = 33;
    localparam int unsigned TAP_MASTER = 13;
    localparam int unsigned TAP_SLAVE  = 20;

    localparam int unsigned SX_TAP_A = 4;
    localparam int unsigned SX_TAP_B = 6;
    localparam int unsigned SY_TAP_A = 1;
    localparam int unsigned SY_TAP_B = 5;

    localparam int unsigned SC_W    = 8;
    localparam int unsigned SY_W    = 4;
    localparam int unsigned SG_W    = 4;
    localparam int unsigned SC_BASE = 16;
    localparam int unsigned SY_BASE = 8;
    localparam int unsigned SG_BASE = 24;

    typedef logic [SCR_W-1:0] scr_state_t;

    localparam scr_state_t SEED_DEFAULT = 33'h1_2345_6789;
    localparam scr_state_t SEED_SAFE    = 33'h0_0000_0001;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    typedef struct packed {
        logic            seq;
        logic [SC_W-1:0] sc;
        logic [SY_W-1:0] sy;
        logic [SG_W-1:0] sg;
    } aux_t;

    function automatic int unsigned role_tap(role_e r);
        return (r == ROLE_MASTER) ? TAP_MASTER : TAP_SLAVE;
    endfunction

    function automatic scr_state_t scr_step(scr_state_t s, role_e r);
        logic fb;
        fb = s[SCR_W-1] ^ s[role_tap(r)-1];
        return {s[SCR_W-2:0], fb};
    endfunction

    function automatic scr_state_t seed_sanitize(scr_state_t s);
        return (s == '0) ? SEED_SAFE : s;
    endfunction

endpackage

// File: rtl/scr_lfsr_core.sv
module scr_lfsr_core
    import ssscr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  scr_state_t seed,
    input  logic       en,
    input  role_e      role,
    output scr_state_t state
);

    scr_state_t state_q;
    scr_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = seed_sanitize(seed);
        end else if (en) begin
            state_d = scr_step(state_q, role);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED_DEFAULT;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    assert_reset_seed_R1: assert property (@(posedge clk)
        rst |=> state_q == SEED_DEFAULT);

    assert_master_fb_R2: assert property (@(posedge clk) disable iff (rst)
        (en && !load && role == ROLE_MASTER)
        |=> state_q[0] == ($past(state_q[32]) ^ $past(state_q[12])));

    assert_slave_fb_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !load && role == ROLE_SLAVE)
        |=> state_q[0] == ($past(state_q[32]) ^ $past(state_q[19])));

    assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> state_q[SCR_W-1:1] == $past(state_q[SCR_W-2:0]));

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        (load && seed != '0) |=> state_q == $past(seed));

    assert_zero_seed_R5: assert property (@(posedge clk) disable iff (rst)
        (load && seed == '0) |=> state_q == SEED_SAFE);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(state_q));

    assert_never_zero_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> state_q != '0);

endmodule

// File: rtl/scr_aux_gen.sv
module scr_aux_gen
    import ssscr_pkg::*;
(
    input  scr_state_t state,
    output aux_t       aux
);

    logic sx;
    logic sy;
    logic unused_state_bits;

    assign sx = state[SX_TAP_A] ^ state[SX_TAP_B];
    assign sy = state[SY_TAP_A] ^ state[SY_TAP_B];

    assign aux.seq = state[0];

    genvar gi;
    generate
        for (gi = 0; gi < SC_W; gi++) begin : g_sc
            if ((gi % 2) == 0) begin : g_even
                assign aux.sc[gi] = state[SC_BASE+gi] ^ sx;
            end else begin : g_odd
                assign aux.sc[gi] = state[SC_BASE+gi] ^ sy;
            end
        end
        for (gi = 0; gi < SY_W; gi++) begin : g_sy
            assign aux.sy[gi] = state[SY_BASE+gi] ^ sy;
        end
        for (gi = 0; gi < SG_W; gi++) begin : g_sg
            assign aux.sg[gi] = state[SG_BASE+gi] ^ sx;
        end
    endgenerate

    assign unused_state_bits = ^state;

endmodule

// File: rtl/side_stream_scrambler.sv
module side_stream_scrambler
    import ssscr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load_i,
    input  logic [32:0] seed_i,
    input  logic        role_master_i,
    input  logic        adv_en_i,
    output logic        seq_bit_o,
    output logic [7:0]  sc_bits_o,
    output logic [3:0]  sy_bits_o,
    output logic [3:0]  sg_bits_o
);

    scr_state_t state;
    aux_t       aux;
    role_e      role;

    assign role = role_e'(role_master_i);

    scr_lfsr_core u_core (
        .clk   (clk),
        .rst   (rst),
        .load  (load_i),
        .seed  (seed_i),
        .en    (adv_en_i),
        .role  (role),
        .state (state)
    );

    scr_aux_gen u_aux (
        .state (state),
        .aux   (aux)
    );

    assign seq_bit_o = aux.seq;
    assign sc_bits_o = aux.sc;
    assign sy_bits_o = aux.sy;
    assign sg_bits_o = aux.sg;

    assert_hold_outputs_R7: assert property (@(posedge clk) disable iff (rst)
        (!adv_en_i && !load_i)
        |=> ($stable(seq_bit_o) && $stable(sc_bits_o)
             && $stable(sy_bits_o) && $stable(sg_bits_o)));

    assert_load_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (load_i && adv_en_i && seed_i != '0) |=> seq_bit_o == $past(seed_i[0]));

    assert_seq_tracks_R8: assert property (@(posedge clk) disable iff (rst)
        (adv_en_i && !load_i) |=> sy_bits_o[0] == ($past(state[7]) ^ $past(state[0]) ^ $past(state[4])));

endmodule

// File: tb/side_stream_scrambler_tb.sv
module side_stream_scrambler_tb;

    localparam bit [32:0] RESET_SEED = 33'h1_2345_6789;

    typedef struct {
        bit        seq;
        bit [7:0]  sc;
        bit [3:0]  sy;
        bit [3:0]  sg;
        bit        adv;
        bit        ld;
        string     req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [32:0] seed_i = '0;
    logic        role_master_i = 1'b1;
    logic        adv_en_i = 1'b0;
    logic        seq_bit_o;
    logic [7:0]  sc_bits_o;
    logic [3:0]  sy_bits_o;
    logic [3:0]  sg_bits_o;

    int checks = 0;
    int errors = 0;
    int zrun = 0;
    int zrun_max = 0;
    bit done = 1'b0;
    bit [32:0] m;
    exp_t q[$];

    always #2 clk = ~clk;

    side_stream_scrambler u_dut (
        .clk           (clk),
        .rst           (rst),
        .load_i        (load_i),
        .seed_i        (seed_i),
        .role_master_i (role_master_i),
        .adv_en_i      (adv_en_i),
        .seq_bit_o     (seq_bit_o),
        .sc_bits_o     (sc_bits_o),
        .sy_bits_o     (sy_bits_o),
        .sg_bits_o     (sg_bits_o)
    );

    // R8 derivation, written from the requirement text
    function automatic exp_t predict(bit [32:0] s, bit adv, bit ld, string req);
        exp_t e;
        bit x, y;
        x = s[4] ^ s[6];
        y = s[1] ^ s[5];
        e.seq = s[0];
        for (int i = 0; i < 8; i++) e.sc[i] = s[16+i] ^ ((i & 1) ? y : x);
        for (int i = 0; i < 4; i++) e.sy[i] = s[8+i] ^ y;
        for (int i = 0; i < 4; i++) e.sg[i] = s[24+i] ^ x;
        e.adv = adv;
        e.ld  = ld;
        e.req = req;
        return e;
    endfunction

    task automatic compare(exp_t e);
        checks++;
        if (seq_bit_o !== e.seq || sc_bits_o !== e.sc || sy_bits_o !== e.sy || sg_bits_o !== e.sg) begin
            errors++;
            $display("FAIL %s: got seq=%0b sc=%02h sy=%01h sg=%01h, expected seq=%0b sc=%02h sy=%01h sg=%01h",
                     e.req, seq_bit_o, sc_bits_o, sy_bits_o, sg_bits_o, e.seq, e.sc, e.sy, e.sg);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected outputs
    task automatic step(bit ld, bit [32:0] sd, bit en, bit mst, string req);
        bit fb;
        @(negedge clk);
        load_i        = ld;
        seed_i        = sd;
        adv_en_i      = en;
        role_master_i = mst;
        if (ld) begin
            m = (sd == 33'd0) ? 33'd1 : sd;
        end else if (en) begin
            fb = m[32] ^ (mst ? m[12] : m[19]);
            m  = {m[31:0], fb};
        end
        q.push_back(predict(m, en && !ld, ld, req));
    endtask

    // monitor: pops one expectation per clock once results are settled
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                compare(e);
                if (e.ld) begin
                    zrun = 0;
                end else if (e.adv) begin
                    if (seq_bit_o == 1'b0) zrun++;
                    else zrun = 0;
                    if (zrun > zrun_max) zrun_max = zrun;
                end
            end
        end
    end

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        m = RESET_SEED;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state visible at the ports
        compare(predict(RESET_SEED, 0, 0, "R1 reset state"));

        // R2: long master run
        for (int i = 0; i < 150; i++) step(0, 33'h0, 1, 1, "R2 master advance");

        // R4: load with enable low, then R3 slave run
        step(1, 33'h0_F00D_CAFE, 0, 0, "R4 load with enable low");
        for (int i = 0; i < 150; i++) step(0, 33'h0, 1, 0, "R3 slave advance");

        // R5: zero seed substitution, then advance past the tap
        step(1, 33'h0, 1, 1, "R5 zero seed becomes 1");
        for (int i = 0; i < 60; i++) step(0, 33'h0, 1, 1, "R5 advance after zero seed");
        step(1, 33'h0, 0, 0, "R5 zero seed with enable low");
        for (int i = 0; i < 60; i++) step(0, 33'h0, 1, 0, "R5 slave after zero seed");

        // R6: load and enable together
        step(1, 33'h1_8000_0003, 1, 1, "R6 load beats enable");
        step(1, 33'h0_5555_AAAA, 1, 0, "R6 back-to-back loads");
        for (int i = 0; i < 20; i++) step(0, 33'h0, 1, 1, "R6 advance after load");

        // R7: hold with seed wiggling
        for (int i = 0; i < 12; i++) step(0, 33'h1_0000_0000 ^ (33'(i) * 33'h0_1357_9BDF), 0, i[0], "R7 hold");
        step(0, 33'h0, 1, 1, "R7 resume after hold");

        // R9: role flips every cycle
        for (int i = 0; i < 100; i++) step(0, 33'h0, 1, i[0], "R9 role toggle");
        for (int i = 0; i < 40; i++) step(0, 33'h0, (i % 3) != 0, (i % 5) < 2, "R9 mixed enable and role");

        drain();

        // R1: reset during a run returns to the default seed
        @(negedge clk);
        rst = 1'b1;
        adv_en_i = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        adv_en_i = 1'b0;
        m = RESET_SEED;
        compare(predict(RESET_SEED, 0, 0, "R1 reset mid-run"));
        for (int i = 0; i < 10; i++) step(0, 33'h0, 1, 1, "R1 advance after reset");
        drain();

        // R10: no zero run on seq_bit reached the register length
        checks++;
        if (zrun_max >= 33) begin
            errors++;
            $display("FAIL R10: longest zero run %0d, expected below 33", zrun_max);
        end

        finish_run();
    end

endmodule